// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block is the target side of a two-wire serial bus that behaves like a small serial EEPROM. It watches the clock line (SCL) and the data line (SDA), both already synchronised to the fast system clock. It finds start and stop conditions, checks the device address, and takes in a word address of one or two bytes, depending on a parameter. It then either stores one data byte or, after a repeated start and a read header, sends out bytes from its internal array. The data line is open-drain. The block only produces an enable that pulls the line low, and it never drives a high level.

A bus master uses it in two ways. To write, it sends a write header, the word address and one data byte, then a stop. To read at a chosen address, it sends a write header and the word address, then a repeated start, then a read header, and then clocks the data out. At reset the array holds contents given by a formula, so a test can predict every byte without loading anything first.

Top module: `eep_slave`

## Requirements
- R1: After reset, `sda_oe` is 0, so the data line is released.
- R2: The target acknowledges a header byte whose upper seven bits equal `DEV_ADDR` (default 7'h50). Bit 0 of the header is the direction: 1 means read, 0 means write. To acknowledge, it drives SDA low for the whole ninth clock. On any other header it does not acknowledge, and it leaves SDA released for all later clocks until the next start.
- R3: After a write header, the target takes the word address, most significant bit first. With `ADDR_BYTES`=1 this is one byte. With `ADDR_BYTES`=2 it is a high byte followed by a low byte. The target acknowledges each address byte. The array index is the word address modulo `MEM_DEPTH`.
- R4: The target acknowledges the first data byte after the word address and stores it at the indexed location. A later read of that location returns it.
- R5: After that data byte, further bytes before a stop or start are neither acknowledged nor stored.
- R6: After a repeated start and a matching read header, the target sends the byte at the current address, most significant bit first.
- R7: After each byte it sends, the target samples the master's ninth bit. If the master acknowledges (SDA low), the address advances by one, wrapping modulo `MEM_DEPTH`, and the next byte follows. If the master does not acknowledge, SDA stays released until the next start.
- R8: A start or stop seen in the middle of a byte abandons that byte. Nothing is stored, and the bit count restarts. After a start the next byte is taken as a header. After a stop the line stays released.
- R9: After reset, the byte at index i is (37*i + 90) mod 256.
- R10: The target changes its SDA drive only while SCL is low, and keeps it steady while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised level of the serial clock line |
| sda_i | input | 1 | Synchronised level of the serial data line |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
Suppose the byte sequencer holds the wrong phase or bit count. The first sign is at the very next ninth clock: the acknowledge is missing or sits in the wrong place, or a data bit is shifted by one position. Both show up within one byte time. A wrong address pointer or array write shows up only when that location is read back. So every write is followed by a random read, and whole sweeps of the array compare each byte returned against the reset formula or the written pattern. A bad abort path shows up as a missing acknowledge on the header that follows a start or stop in the middle of a byte.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_WDATA,
    PH_RDATA
  } phase_t;

  // reset content of cell idx
  function automatic logic [7:0] init_byte(input int unsigned idx);
    return 8'((idx * 37 + 90) % 256);
  endfunction

  // header byte carries the expected seven-bit device address
  function automatic logic hdr_match(input logic [7:0] hdr, input logic [6:0] dev);
    return hdr[7:1] == dev;
  endfunction

  // next word address; a one-byte address keeps its upper byte at zero
  function automatic logic [15:0] bump_addr(input logic [15:0] a, input logic two);
    if (two) return a + 16'd1;
    return {8'h00, a[7:0] + 8'd1};
  endfunction

endpackage

// File: rtl/eep_line_mon.sv
module eep_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_evt = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_evt  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int DEPTH = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [15:0] waddr,
  input  logic [7:0]  wdata,
  input  logic [15:0] raddr,
  output logic [7:0]  rdata
);
  import eep_pkg::*;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    cells [DEPTH];
  logic [AW-1:0] widx, ridx;

  assign widx  = AW'(waddr % 16'(DEPTH));
  assign ridx  = AW'(raddr % 16'(DEPTH));
  assign rdata = cells[ridx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= init_byte(i);
    end else if (we) begin
      cells[widx] <= wdata;
    end
  end
endmodule

// File: rtl/eep_slave.sv
module eep_slave #(
  parameter logic [6:0] DEV_ADDR   = 7'h50,
  parameter int         ADDR_BYTES = 1,
  parameter int         MEM_DEPTH  = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  import eep_pkg::*;
  localparam bit TWO = (ADDR_BYTES == 2);

  logic scl_rise, scl_fall, start_evt, stop_evt;
  phase_t      phase, nxt;
  logic [3:0]  bit_cnt;
  logic [7:0]  shreg, tx;
  logic [15:0] ptr, rd_addr;
  logic [7:0]  rd_data;
  logic        oe_q, m_ack;
  logic        byte_ack, mem_we;
  phase_t      byte_next;

  eep_line_mon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  // while sending, the port looks one address ahead for the next byte
  assign rd_addr = (phase == PH_RDATA) ? bump_addr(ptr, TWO) : ptr;
  assign mem_we  = scl_fall && !start_evt && !stop_evt &&
                   (phase == PH_WDATA) && (bit_cnt == 4'd8);

  eep_mem #(.DEPTH(MEM_DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(ptr), .wdata(shreg),
    .raddr(rd_addr), .rdata(rd_data)
  );

  // decision on a fully received byte
  always_comb begin
    byte_ack  = 1'b0;
    byte_next = PH_IDLE;
    case (phase)
      PH_DEV: if (hdr_match(shreg, DEV_ADDR)) begin
        byte_ack  = 1'b1;
        byte_next = shreg[0] ? PH_RDATA : (TWO ? PH_AHI : PH_ALO);
      end
      PH_AHI:   begin byte_ack = 1'b1; byte_next = PH_ALO;   end
      PH_ALO:   begin byte_ack = 1'b1; byte_next = PH_WDATA; end
      PH_WDATA: begin byte_ack = 1'b1; byte_next = PH_IDLE;  end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      nxt     <= PH_IDLE;
      bit_cnt <= 4'd0;
      shreg   <= 8'd0;
      tx      <= 8'd0;
      ptr     <= 16'd0;
      oe_q    <= 1'b0;
      m_ack   <= 1'b0;
    end else if (stop_evt) begin
      phase   <= PH_IDLE;
      bit_cnt <= 4'd0;
      oe_q    <= 1'b0;
    end else if (start_evt) begin
      phase   <= PH_DEV;
      bit_cnt <= 4'd0;
      oe_q    <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (scl_rise) begin
        if (bit_cnt < 4'd8) begin
          shreg   <= {shreg[6:0], sda_i};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (bit_cnt == 4'd8) begin
          m_ack   <= !sda_i;
          bit_cnt <= 4'd9;
        end
      end else if (scl_fall) begin
        if (phase == PH_RDATA) begin
          if (bit_cnt >= 4'd1 && bit_cnt <= 4'd7) begin
            tx   <= {tx[6:0], 1'b0};
            oe_q <= !tx[6];
          end else if (bit_cnt == 4'd8) begin
            oe_q <= 1'b0;
          end else if (bit_cnt == 4'd9) begin
            bit_cnt <= 4'd0;
            if (m_ack) begin
              ptr  <= bump_addr(ptr, TWO);
              tx   <= rd_data;
              oe_q <= !rd_data[7];
            end else begin
              phase <= PH_IDLE;
              oe_q  <= 1'b0;
            end
          end
        end else begin
          if (bit_cnt == 4'd8) begin
            oe_q <= byte_ack;
            nxt  <= byte_next;
            if (phase == PH_AHI) ptr[15:8] <= shreg;
            if (phase == PH_ALO) ptr[7:0]  <= shreg;
          end else if (bit_cnt == 4'd9) begin
            bit_cnt <= 4'd0;
            phase   <= nxt;
            if (nxt == PH_RDATA) begin
              tx   <= rd_data;
              oe_q <= !rd_data[7];
            end else begin
              oe_q <= 1'b0;
            end
          end
        end
      end
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       mem_we,
  input logic [3:0] bit_cnt
);
  // R10: drive changes only in the low half of SCL
  p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R6: a bit put on the line stays while SCL is high
  p_hold_while_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe));

  // R8: a start clears the byte in progress and releases the line
  p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!sda_oe && bit_cnt == 4'd0));

  // R8: a stop releases the line
  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R4: a stored byte is always acknowledged
  p_write_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sda_oe);
endmodule

bind eep_slave eep_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .start_evt(start_evt), .stop_evt(stop_evt), .mem_we(mem_we), .bit_cnt(bit_cnt)
);

// File: tb/tb_eep_slave.sv
module tb_eep_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic oe_a, oe_b;
  wire  sda_bus;
  int   n_run = 0;
  int   n_fail = 0;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~oe_a & ~oe_b;

  eep_slave dut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(oe_a));
  eep_slave #(.DEV_ADDR(7'h51), .ADDR_BYTES(2), .MEM_DEPTH(64)) dut2 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(oe_b));

  function automatic logic [7:0] seed_val(input int i);
    return 8'((i * 37 + 90) & 255);
  endfunction
  function automatic logic [7:0] pat2(input int a);
    return 8'(((a * 5 + 1) & 255) ^ 8'h3C);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (4) @(negedge clk);
  endtask

  task automatic start_c();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; hp();
    end
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    put_bits(b, 8);
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp();
    ack = !sda_bus;
    scl_m = 1'b0; hp();
  endtask

  task automatic get_byte(input logic ack_m, output logic [7:0] b);
    logic s1;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp(); scl_m = 1'b1;
      @(negedge clk); s1 = sda_bus;
      repeat (3) @(negedge clk);
      b[i] = sda_bus;
      chk("R10", {31'd0, b[i]}, {31'd0, s1});
      scl_m = 1'b0;
    end
    hp(); sda_m = !ack_m; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; hp(); sda_m = 1'b1;
  endtask

  // set the pointer of the default target and open a read
  task automatic open_read_a(input logic [7:0] addr);
    logic k;
    start_c(); put_byte(8'hA0, k); chk("R2", {31'd0, k}, 1);
    put_byte(addr, k); chk("R3", {31'd0, k}, 1);
    start_c(); put_byte(8'hA1, k); chk("R6", {31'd0, k}, 1);
  endtask

  task automatic open_read_b(input logic [7:0] hi, input logic [7:0] lo);
    logic k;
    start_c(); put_byte(8'hA2, k); chk("R2", {31'd0, k}, 1);
    put_byte(hi, k); chk("R3", {31'd0, k}, 1);
    put_byte(lo, k); chk("R3", {31'd0, k}, 1);
    start_c(); put_byte(8'hA3, k); chk("R6", {31'd0, k}, 1);
  endtask

  initial begin
    repeat (1900000 / 10) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic k;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    chk("R1", {30'd0, oe_a, oe_b}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", {31'd0, sda_bus}, 1);

    // R2: matching and non-matching headers
    start_c(); put_byte(8'hA0, k); chk("R2", {31'd0, k}, 1); stop_c();
    start_c(); put_byte(8'hA2, k); chk("R2", {31'd0, k}, 1); stop_c();
    start_c(); put_byte(8'hA6, k); chk("R2", {31'd0, k}, 0);
    put_byte(8'h12, k); chk("R2", {31'd0, k}, 0);
    get_byte(1'b0, b); chk("R2", {24'd0, b}, 32'hFF);
    stop_c();

    // R9 R6 R7: sweep the whole default array
    open_read_a(8'h00);
    for (int i = 0; i < 256; i++) begin
      get_byte(i < 255, b);
      chk("R9", {24'd0, b}, {24'd0, seed_val(i)});
    end
    get_byte(1'b0, b); chk("R7", {24'd0, b}, 32'hFF);
    stop_c();

    // R7: wrap past the last cell
    open_read_a(8'hFF);
    get_byte(1'b1, b); chk("R7", {24'd0, b}, {24'd0, seed_val(255)});
    get_byte(1'b0, b); chk("R7", {24'd0, b}, {24'd0, seed_val(0)});
    stop_c();

    // R4 R5: single byte write, extra byte refused
    start_c(); put_byte(8'hA0, k); chk("R4", {31'd0, k}, 1);
    put_byte(8'h33, k); chk("R3", {31'd0, k}, 1);
    put_byte(8'hC5, k); chk("R4", {31'd0, k}, 1);
    put_byte(8'h77, k); chk("R5", {31'd0, k}, 0);
    stop_c();
    open_read_a(8'h33);
    get_byte(1'b1, b); chk("R4", {24'd0, b}, 32'hC5);
    get_byte(1'b0, b); chk("R5", {24'd0, b}, {24'd0, seed_val(8'h34)});
    stop_c();

    // R3: two-byte address, index wraps modulo depth
    start_c(); put_byte(8'hA2, k); chk("R3", {31'd0, k}, 1);
    put_byte(8'h01, k); chk("R3", {31'd0, k}, 1);
    put_byte(8'h05, k); chk("R3", {31'd0, k}, 1);
    put_byte(8'h9E, k); chk("R4", {31'd0, k}, 1);
    stop_c();
    open_read_b(8'h00, 8'h05);
    get_byte(1'b0, b); chk("R3", {24'd0, b}, 32'h9E);
    stop_c();

    // R4 R7: fill and read back the small array
    for (int a = 0; a < 64; a++) begin
      start_c(); put_byte(8'hA2, k);
      put_byte(8'h00, k); put_byte(8'(a), k);
      put_byte(pat2(a), k); chk("R4", {31'd0, k}, 1);
      stop_c();
    end
    open_read_b(8'h00, 8'h00);
    for (int i = 0; i <= 64; i++) begin
      get_byte(i < 64, b);
      chk("R7", {24'd0, b}, {24'd0, pat2(i % 64)});
    end
    stop_c();

    // R8: start inside a header, then a clean random read
    start_c(); put_bits(8'hA0, 4);
    open_read_a(8'h20);
    get_byte(1'b0, b); chk("R8", {24'd0, b}, {24'd0, seed_val(8'h20)});
    stop_c();

    // R8: stop inside a header
    start_c(); put_bits(8'hA0, 3); stop_c();
    hp(); chk("R8", {31'd0, sda_bus}, 1);
    open_read_a(8'h21);
    get_byte(1'b0, b); chk("R8", {24'd0, b}, {24'd0, seed_val(8'h21)});
    stop_c();

    // R8: stop inside a data byte stores nothing
    start_c(); put_byte(8'hA0, k); put_byte(8'h40, k); put_bits(8'h00, 5); stop_c();
    open_read_a(8'h40);
    get_byte(1'b0, b); chk("R8", {24'd0, b}, {24'd0, seed_val(8'h40)});
    stop_c();

    hp();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule